// File: doc/BRIEF.md
# Counted Byte Block-Copy Sequencer

This block moves a run of bytes from one region of memory to another through a plain synchronous memory port. A single start pulse loads a 32-bit source pointer, a 32-bit destination pointer, a 16-bit count and a width selector. The selector decides whether only the low byte of the count or all sixteen bits give the number of bytes to move. The sequencer then alternates read and write cycles, one byte per pair, until the selected count reaches zero.

On completion the block presents both pointers advanced past the copied region and the count with its selected part at zero, and it pulses `done` for one cycle. The run time is fixed and predictable: two cycles of lead-in, two per byte, and two of wind-down, so a count of n takes 4+2n cycles. A selected count of zero makes no memory access and finishes after the four overhead cycles.

Top module: `blkcopy_engine`

## Requirements
- R1: While `rst_n` is low and after its release with no start, `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: A start accepted while idle raises `busy` in the next cycle; `busy` stays high for exactly 4+2n cycles, where n is the selected count, and `done` is high only in the final one of them.
- R3: Byte k (k counting from 0) is copied by a cycle with `mem_rd`=1 and `mem_addr`=source+k, followed at once by a cycle with `mem_wr`=1, `mem_addr`=destination+k and `mem_wdata` equal to the byte returned on `mem_rdata` for that read.
- R4: In the `done` cycle, `src_out` equals source+n, `dst_out` equals destination+n, and the selected part of `cnt_out` is 0.
- R5: With `wide_in`=0 only `cnt_in[7:0]` sets n and `cnt_out[15:8]` equals `cnt_in[15:8]`; with `wide_in`=1 all 16 bits of `cnt_in` set n.
- R6: When the selected count is 0 at start, no memory access is made, `busy` lasts 4 cycles, and the outputs at `done` equal the inputs given at start.
- R7: A start pulse while `busy` is high has no effect on timing, memory accesses or final outputs of the copy in progress.
- R8: Pointer increments wrap modulo 2^32 (0xFFFFFFFF + 1 = 0x00000000).
- R9: `mem_rd` and `mem_wr` are never high in the same cycle, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a copy (taken only while idle) |
| src_in | input | 32 | Initial source pointer |
| dst_in | input | 32 | Initial destination pointer |
| cnt_in | input | 16 | Byte count |
| wide_in | input | 1 | 1: 16-bit count, 0: low 8 bits only |
| mem_addr | output | 32 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 32 | Current/final source pointer |
| dst_out | output | 32 | Current/final destination pointer |
| cnt_out | output | 16 | Current/final count |

## Verification
A wrong sequencer state shows up as a misplaced strobe on the memory port within one cycle: a write without a preceding read, two strobes together, or a strobe outside `busy`. A faulty pointer or count update reveals itself on `mem_addr` at the very next byte and, for the count, as a run that is too long or too short, visible as a `done` pulse off the 4+2n mark. Upper count bits corrupted in narrow mode are seen on `cnt_out` at the `done` cycle.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD0 = 3'd1,
    ST_LEAD1 = 3'd2,
    ST_FETCH = 3'd3,
    ST_STORE = 3'd4,
    ST_TAIL0 = 3'd5,
    ST_TAIL1 = 3'd6
  } step_e;
endpackage

// File: rtl/blkcopy_regs.sv
module blkcopy_regs #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              wide_in,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              sel_zero,
  output logic              sel_one
);
  localparam int HIGH_W = CNT_W - NARROW_W;

  logic wide_q;

  // selected portion of the count, zero-extended
  function automatic logic [CNT_W-1:0] sel_count(input logic [CNT_W-1:0] c, input logic w);
    return w ? c : {{HIGH_W{1'b0}}, c[NARROW_W-1:0]};
  endfunction

  // decrement only the selected portion; unselected bits pass through
  function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] c, input logic w);
    logic [NARROW_W-1:0] lo;
    lo = c[NARROW_W-1:0] - NARROW_W'(1);
    return w ? (c - CNT_W'(1)) : {c[CNT_W-1:NARROW_W], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  assign sel_zero = (sel_count(cnt_q, wide_q) == '0);
  assign sel_one  = (sel_count(cnt_q, wide_q) == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      wide_q <= 1'b0;
    end else if (load) begin
      src_q  <= src_in;
      dst_q  <= dst_in;
      cnt_q  <= cnt_in;
      wide_q <= wide_in;
    end else if (advance) begin
      src_q  <= bump(src_q);
      dst_q  <= bump(dst_q);
      cnt_q  <= dec_count(cnt_q, wide_q);
    end
  end

  // R4
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load |=> src_q == $past(src_q) + ADDR_W'(1));
  // R8
  dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load |=> dst_q == $past(dst_q) + ADDR_W'(1));
  // R5
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load && !wide_q |=> cnt_q[CNT_W-1:NARROW_W] == $past(cnt_q[CNT_W-1:NARROW_W]));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !sel_zero);
endmodule

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
  import blkcopy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_zero,
  input  logic sel_one,
  output logic accept,
  output logic fetch,
  output logic store,
  output logic busy,
  output logic done
);
  step_e st_q, st_d;

  assign accept = (st_q == ST_IDLE) && start;
  assign fetch  = (st_q == ST_FETCH);
  assign store  = (st_q == ST_STORE);
  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_TAIL1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_LEAD0;
      ST_LEAD0: st_d = ST_LEAD1;
      ST_LEAD1: st_d = sel_zero ? ST_TAIL0 : ST_FETCH;
      ST_FETCH: st_d = ST_STORE;
      ST_STORE: st_d = sel_one ? ST_TAIL0 : ST_FETCH;
      ST_TAIL0: st_d = ST_TAIL1;
      ST_TAIL1: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch && store));
  // R3
  store_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> store);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && start |=> busy);
  // R6
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEAD1) && sel_zero |=> !fetch ##1 !fetch);
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              wide_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] src_out,
  output logic [ADDR_W-1:0] dst_out,
  output logic [CNT_W-1:0]  cnt_out
);
  logic accept, fetch, store, sel_zero, sel_one;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;

  blkcopy_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sel_zero (sel_zero),
    .sel_one  (sel_one),
    .accept   (accept),
    .fetch    (fetch),
    .store    (store),
    .busy     (busy),
    .done     (done)
  );

  blkcopy_regs #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .advance  (store),
    .src_in   (src_in),
    .dst_in   (dst_in),
    .cnt_in   (cnt_in),
    .wide_in  (wide_in),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .cnt_q    (cnt_q),
    .sel_zero (sel_zero),
    .sel_one  (sel_one)
  );

  assign mem_rd    = fetch;
  assign mem_wr    = store;
  assign mem_addr  = store ? dst_q : src_q;
  assign mem_wdata = mem_rdata;
  assign src_out   = src_q;
  assign dst_out   = dst_q;
  assign cnt_out   = cnt_q;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd && !mem_wr);
  // R3
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  // R4
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sel_zero);
endmodule

// File: tb/tb_blkcopy_engine.sv
module tb_blkcopy_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BITS   = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_in = '0, dst_in = '0;
  logic [15:0] cnt_in = '0;
  logic        wide_in = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [31:0] src_out, dst_out;
  logic [15:0] cnt_out;

  logic [7:0] mem [1 << MEM_BITS];
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkcopy_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .wide_in(wide_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << MEM_BITS); i++) mem[i] <= 8'(i * 37 + 11);
      mem_rdata <= '0;
    end else begin
      if (mem_rd) mem_rdata <= mem[mem_addr[MEM_BITS-1:0]];
      if (mem_wr) mem[mem_addr[MEM_BITS-1:0]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one copy scenario; inject=1 pulses start with junk inputs mid-run
  task automatic run_copy(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c,
                          input logic w, input bit inject, input string tag);
    int n, cyc, k_rd, k_wr;
    bit seq_ok, wd_ok, quiet_ok, mem_ok;
    logic [15:0] cexp;
    n = w ? int'(c) : int'(c[7:0]);
    cexp = w ? 16'h0000 : {c[15:8], 8'h00};
    @(negedge clk);
    src_in = s; dst_in = d; cnt_in = c; wide_in = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    src_in = 32'hDEAD_BEEF; dst_in = 32'h1234_5678; cnt_in = 16'h00FF; wide_in = 1'b1;
    cyc = 1; k_rd = 0; k_wr = 0; seq_ok = 1; wd_ok = 1; quiet_ok = 1;
    forever begin
      if (!busy) begin
        chk(0, {tag, " R2 busy dropped early"}, 64'(cyc), 64'(4 + 2 * n));
        break;
      end
      if (mem_rd && mem_wr) quiet_ok = 0;               // R9
      if (mem_rd) begin                                  // R3 / R8
        if (mem_addr != s + 32'(k_rd) || k_rd != k_wr) seq_ok = 0;
        k_rd++;
      end
      if (mem_wr) begin
        if (mem_addr != d + 32'(k_wr) || k_wr + 1 != k_rd) seq_ok = 0;
        if (mem_wdata != mem[(s[MEM_BITS-1:0] + MEM_BITS'(k_wr))]) wd_ok = 0;
        k_wr++;
      end
      if (done) break;
      if (inject && cyc == 3) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (cyc > 5000) break;
    end
    start = 1'b0;
    chk(cyc == 4 + 2 * n, {tag, " R2 done cycle"}, 64'(cyc), 64'(4 + 2 * n));
    chk(k_wr == n && k_rd == n, {tag, " R3 byte count"}, 64'(k_wr), 64'(n));
    chk(seq_ok, {tag, " R3 address sequence"}, 64'(seq_ok), 64'd1);
    chk(wd_ok, {tag, " R3 write data"}, 64'(wd_ok), 64'd1);
    chk(quiet_ok, {tag, " R9 strobe overlap"}, 64'(quiet_ok), 64'd1);
    chk(src_out == s + 32'(n), {tag, " R4 src_out"}, 64'(src_out), 64'(s + 32'(n)));
    chk(dst_out == d + 32'(n), {tag, " R4 dst_out"}, 64'(dst_out), 64'(d + 32'(n)));
    chk(cnt_out == cexp, {tag, " R5 cnt_out"}, 64'(cnt_out), 64'(cexp));
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, {tag, " R2 idle after done"}, 64'({busy, done}), 64'd0);
    mem_ok = 1;
    for (int k = 0; k < n; k++)
      if (mem[d[MEM_BITS-1:0] + MEM_BITS'(k)] != mem[s[MEM_BITS-1:0] + MEM_BITS'(k)]) mem_ok = 0;
    chk(mem_ok, {tag, " R3 memory contents"}, 64'(mem_ok), 64'd1);
  endtask

  task automatic test_reset();
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 in reset", 64'({busy, done, mem_rd, mem_wr}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 after release", 64'({busy, done, mem_rd, mem_wr}), 64'd0);
  endtask

  task automatic test_narrow();
    run_copy(32'h0000_0010, 32'h0000_0200, 16'hAB05, 1'b0, 0, "narrow R5");
  endtask

  task automatic test_wide();
    run_copy(32'h0000_0100, 32'h0000_0300, 16'd300, 1'b1, 0, "wide R5");
  endtask

  task automatic test_zero();
    run_copy(32'h0000_0040, 32'h0000_0050, 16'h0500, 1'b0, 0, "zero-narrow R6");
    run_copy(32'h0000_0060, 32'h0000_0070, 16'h0000, 1'b1, 0, "zero-wide R6");
  endtask

  task automatic test_busy_start();
    run_copy(32'h0000_0020, 32'h0000_0380, 16'h0003, 1'b0, 1, "restart R7");
  endtask

  task automatic test_wrap();
    run_copy(32'hFFFF_FFFE, 32'h0000_0080, 16'h0004, 1'b1, 0, "wrap R8");
  endtask

  task automatic test_single();
    run_copy(32'h0000_01F0, 32'h0000_0005, 16'h0001, 1'b1, 0, "single R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_narrow();
    test_wide();
    test_zero();
    test_busy_start();
    test_wrap();
    test_single();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule